// File: doc/BRIEF.md
# TDM Receive Slot Capture

This block is the receive half of a time-division-multiplexed audio serial port. Serial bits arrive one per shift-clock enable and are assembled MSB first into words of `WORD_W` bits. A frame sync pulse marks the first bit of slot 0. A slot counter then follows the words of the frame one after another. Every slot of the frame is shifted in, but a finished word is kept only when its slot is enabled in the assignment mask.

Each slot has its own holding register with a full flag. In DMA mode the slot's request line follows the full flag until the slot's acknowledge empties it. In interrupt mode a single receive interrupt pulses once for each captured word. A word that arrives while its slot is still full replaces the old one. A sticky per-slot lost-data flag records each such replacement, and writing 1 to the matching clear bit removes it.

Top module: `tdm_rx_slot_dma`

## Requirements
- R1: Bits are sampled only in cycles where `sclk_en` is 1 and are assembled MSB first. A cycle with both `sclk_en` and `fsync` at 1 carries the MSB of slot 0. No word is captured before the first frame sync after reset.
- R2: Slots are numbered from 0 in the order they arrive after frame sync. Words that arrive after slot `SLOTS-1` and before the next frame sync are shifted in but never captured.
- R3: The word that completes slot n is written to `slot_data[n*WORD_W +: WORD_W]` only when `slot_mask[n]` is 1 in the cycle of its last bit. When the mask bit is 0, that slot's data, flags and interrupt stay unchanged.
- R4: A capture sets the slot's full flag at the clock edge of the last bit. In DMA mode (`dma_mode`=1), `dma_req[n]` is 1 exactly while slot n is full.
- R5: `dma_ack[n]` in a cycle with no capture for slot n empties the slot, so `dma_req[n]` is 0 from the next cycle.
- R6: When an acknowledge and a capture for the same slot fall in the same cycle, the slot stays full with the new word and no overwrite is recorded.
- R7: A capture into a full slot with no acknowledge in that cycle replaces the data and sets `ovw_flag[n]`. The flag holds until a cycle with `ovw_clr[n]`=1 and no new overwrite; a new overwrite in the same cycle as the clear wins.
- R8: In interrupt mode (`dma_mode`=0), `dma_req` is all zero and `rx_irq` is 1 for one cycle after each cycle holding one or more captures. In DMA mode `rx_irq` stays 0.
- R9: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_en | input | 1 | One-cycle strobe per serial bit |
| fsync | input | 1 | Frame sync, valid with `sclk_en`, marks the first bit of slot 0 |
| sdata_in | input | 1 | Serial receive data |
| slot_mask | input | SLOTS | Slot assignment mask |
| dma_mode | input | 1 | 1 selects DMA requests, 0 selects the receive interrupt |
| dma_ack | input | SLOTS | Per-slot acknowledge that empties the slot register |
| ovw_clr | input | SLOTS | Write-1-to-clear for the lost-data flags |
| slot_data | output | SLOTS*WORD_W | Per-slot holding registers, slot n at bits n*WORD_W upward |
| dma_req | output | SLOTS | Per-slot DMA request |
| ovw_flag | output | SLOTS | Sticky per-slot lost-data flags |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench aims at five cases: a frame with more words than slots, an unassigned slot, an acknowledge that lands in the same cycle as a new capture, a lost-data clear that lands with a fresh overwrite, and serial traffic before the first sync. A slot counter that wraps instead of saturating would write the extra word into slot 0. A missing mask check would change the data of an unassigned slot. Letting the acknowledge win would drop a request for a word that is sitting in the slot. Letting the clear win would hide data that was just lost, and capturing before sync would raise requests for misaligned words.

// File: rtl/tdm_rx_slot_dma.sv
module tdm_rx_slot_dma #(
  parameter int SLOTS  = 4,
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk_en,
  input  logic                      fsync,
  input  logic                      sdata_in,
  input  logic [SLOTS-1:0]          slot_mask,
  input  logic                      dma_mode,
  input  logic [SLOTS-1:0]          dma_ack,
  input  logic [SLOTS-1:0]          ovw_clr,
  output logic [SLOTS*WORD_W-1:0]   slot_data,
  output logic [SLOTS-1:0]          dma_req,
  output logic [SLOTS-1:0]          ovw_flag,
  output logic                      rx_irq
);
  localparam int BCW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int SCW = $clog2(SLOTS + 1);

  logic [WORD_W-1:0] shreg;
  logic [BCW-1:0]    bit_cnt;
  logic [SCW-1:0]    slot_cnt;
  logic              synced;
  logic [SLOTS-1:0]  full, cap;
  logic [WORD_W-1:0] data_q [SLOTS];

  wire [WORD_W-1:0] word_nx = {shreg[WORD_W-2:0], sdata_in};
  wire last_bit = sclk_en && !fsync && synced && (bit_cnt == BCW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg    <= '0;
      bit_cnt  <= '0;
      slot_cnt <= '0;
      synced   <= 1'b0;
    end else if (sclk_en) begin
      shreg <= word_nx;
      if (fsync) begin
        bit_cnt  <= BCW'(1);
        slot_cnt <= '0;
        synced   <= 1'b1;
      end else if (last_bit) begin
        bit_cnt <= '0;
        if (slot_cnt != SCW'(SLOTS)) slot_cnt <= slot_cnt + 1'b1;
      end else if (synced) begin
        bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= !dma_mode && (|cap);
  end

  assign dma_req = dma_mode ? full : '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign cap[i] = last_bit && (slot_cnt == SCW'(i)) && slot_mask[i];
    assign slot_data[i*WORD_W +: WORD_W] = data_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i]   <= '0;
        full[i]     <= 1'b0;
        ovw_flag[i] <= 1'b0;
      end else begin
        if (cap[i]) data_q[i] <= word_nx;
        full[i]     <= cap[i] || (full[i] && !dma_ack[i]);
        ovw_flag[i] <= (cap[i] && full[i] && !dma_ack[i]) || (ovw_flag[i] && !ovw_clr[i]);
      end
    end

    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cap[i] |=> $stable(data_q[i]));
    a_r4_capture_fills: assert property (@(posedge clk) disable iff (!rst_n)
      cap[i] |=> full[i]);
    a_r5_ack_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack[i] && !cap[i]) |=> !full[i]);
    a_r6_ack_with_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_ack[i] && cap[i]) |=> (full[i] && $stable(ovw_flag[i])));
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovw_flag[i] && !ovw_clr[i]) |=> ovw_flag[i]);
  end

  a_r1_no_capture_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_en && fsync) |-> (cap == '0));
  a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slot_cnt <= SCW'(SLOTS));
  a_r8_no_req_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_mode |-> (dma_req == '0));
  a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && cap == '0) |=> !rx_irq);
endmodule

// File: tb/tdm_rx_slot_dma_tb_top.sv
module tdm_rx_slot_dma_tb_top;
  localparam int S = 4;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic sclk_en = 0, fsync = 0, sdata_in = 0, dma_mode = 1;
  logic [S-1:0] slot_mask = '1, dma_ack = '0, ovw_clr = '0;
  logic [S*W-1:0] slot_data;
  logic [S-1:0] dma_req, ovw_flag;
  logic rx_irq;

  int checks = 0, fails = 0;

  tdm_rx_slot_dma #(.SLOTS(S), .WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .fsync(fsync), .sdata_in(sdata_in),
    .slot_mask(slot_mask), .dma_mode(dma_mode), .dma_ack(dma_ack), .ovw_clr(ovw_clr),
    .slot_data(slot_data), .dma_req(dma_req), .ovw_flag(ovw_flag), .rx_irq(rx_irq));

  always #2 clk = ~clk;

  // reference model
  bit q[$];
  int m_slot = 0;
  bit m_sync = 0;
  logic [W-1:0] m_data [S];
  bit m_full [S];
  bit m_ovw [S];
  bit m_irq = 0;

  always @(posedge clk) begin
    bit cap [S];
    logic [W-1:0] w;
    for (int i = 0; i < S; i++) cap[i] = 0;
    w = '0;
    if (!rst_n) begin
      q = {}; m_slot = 0; m_sync = 0; m_irq = 0;
      for (int i = 0; i < S; i++) begin m_data[i] = '0; m_full[i] = 0; m_ovw[i] = 0; end
    end else begin
      if (sclk_en) begin
        if (fsync) begin q = {}; m_slot = 0; m_sync = 1; q.push_back(sdata_in); end
        else if (m_sync) begin
          q.push_back(sdata_in);
          if (q.size() == W) begin
            foreach (q[k]) w = {w[W-2:0], q[k]};
            q = {};
            if (m_slot < S) begin
              if (slot_mask[m_slot]) cap[m_slot] = 1;
              m_slot++;
            end
          end
        end
      end
      m_irq = 0;
      for (int i = 0; i < S; i++) begin
        if (cap[i] && !dma_mode) m_irq = 1;
        if (cap[i]) begin
          if (m_full[i] && !dma_ack[i]) m_ovw[i] = 1;
          else if (ovw_clr[i]) m_ovw[i] = 0;
          m_data[i] = w;
          m_full[i] = 1;
        end else begin
          if (ovw_clr[i]) m_ovw[i] = 0;
          if (dma_ack[i]) m_full[i] = 0;
        end
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [S-1:0] er, eo;
    logic [S*W-1:0] ed;
    for (int i = 0; i < S; i++) begin
      er[i] = dma_mode && m_full[i];
      eo[i] = m_ovw[i];
      ed[i*W +: W] = m_data[i];
    end
    chk("R3 slot_data", 64'(slot_data), 64'(ed));
    chk("R4 dma_req", 64'(dma_req), 64'(er));
    chk("R7 ovw_flag", 64'(ovw_flag), 64'(eo));
    chk("R8 rx_irq", 64'(rx_irq), 64'(m_irq));
  end

  task automatic bit_out(bit b, bit fs, logic [S-1:0] ack = '0, logic [S-1:0] clr = '0);
    @(negedge clk);
    sclk_en = 1; fsync = fs; sdata_in = b; dma_ack = ack; ovw_clr = clr;
    @(negedge clk);
    sclk_en = 0; fsync = 0; dma_ack = '0; ovw_clr = '0;
  endtask

  task automatic word_out(logic [W-1:0] w, bit fs, logic [S-1:0] ack = '0, logic [S-1:0] clr = '0);
    for (int k = W - 1; k >= 0; k--)
      bit_out(w[k], fs && (k == W - 1), (k == 0) ? ack : '0, (k == 0) ? clr : '0);
  endtask

  task automatic pulse(logic [S-1:0] ack, logic [S-1:0] clr);
    @(negedge clk);
    dma_ack = ack; ovw_clr = clr;
    @(negedge clk);
    dma_ack = '0; ovw_clr = '0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 64'({slot_data, dma_req, ovw_flag, rx_irq}), 64'(0));
    rst_n = 1;
    // R1: traffic before first sync is ignored
    word_out(16'hFFFF, 0); word_out(16'h1234, 0);
    @(negedge clk); chk("R1 no capture before sync", 64'(dma_req), 64'(0));
    // R1/R3/R4: full frame, MSB first
    word_out(16'hA5C3, 1); word_out(16'h0001, 0); word_out(16'h8000, 0); word_out(16'h7E18, 0);
    @(negedge clk);
    chk("R1 MSB first slot0", 64'(slot_data[0 +: W]), 64'(16'hA5C3));
    chk("R2 slot3 word", 64'(slot_data[3*W +: W]), 64'(16'h7E18));
    chk("R4 all requests", 64'(dma_req), 64'(4'hF));
    // R5: ack slot 0
    pulse(4'b0001, '0);
    @(negedge clk); chk("R5 ack drops request", 64'(dma_req), 64'(4'hE));
    // R2/R7: extra slot word discarded, slots 1..3 overwritten; R6 ack with capture on slot 1
    word_out(16'h1111, 1); word_out(16'h2222, 0, 4'b0010); word_out(16'h3333, 0);
    word_out(16'h4444, 0); word_out(16'h5555, 0);
    @(negedge clk);
    chk("R2 extra word dropped", 64'(slot_data[0 +: W]), 64'(16'h1111));
    chk("R6 ack with capture keeps full", 64'(dma_req[1]), 64'(1));
    chk("R7 overwrite flags", 64'(ovw_flag), 64'(4'b1100));
    // R7: clear slot 2, clear slot 3 while new overwrite
    pulse('0, 4'b0100);
    word_out(16'h0F0F, 1); word_out(16'h0, 0); word_out(16'h0, 0); word_out(16'hBEEF, 0, '0, 4'b1000);
    @(negedge clk);
    chk("R7 set wins over clear", 64'(ovw_flag[3]), 64'(1));
    pulse(4'hF, 4'hF);
    @(negedge clk); chk("R7 flags cleared", 64'(ovw_flag), 64'(0));
    // R3/R8: interrupt mode with partial mask
    dma_mode = 0; slot_mask = 4'b0101;
    word_out(16'hC001, 1); word_out(16'hDEAD, 0); word_out(16'hCAFE, 0); word_out(16'hF00D, 0);
    @(negedge clk);
    chk("R3 unassigned slot unchanged", 64'(slot_data[1*W +: W]), 64'(16'h0));
    chk("R3 assigned slot captured", 64'(slot_data[2*W +: W]), 64'(16'hCAFE));
    chk("R8 no requests in irq mode", 64'(dma_req), 64'(0));
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule